// File: doc/BRIEF.md
# Redundant Bank-Select Decoder with Comparator Self-Test

This block decodes the bank field of an on-chip RAM address twice, in a primary and in a redundant decoder, and drives the RAM's one-hot bank select from the primary copy. On every valid access a comparator checks the two one-hot outputs against each other. If they differ, a sticky decode-failure flag is raised in a write-one-to-clear status register.

The comparator itself can be exercised from software through a small register port. Software first stores a key and a mode in the control register and a pattern in the test-vector register. It then clears the status flags and writes the start bit. The block then runs a short test of fixed length. During the test, RAM accesses are held off, and the decoders are fed from the test vector instead of the access address.

There are two test modes:
- In equal mode, both decoders see the same address. A passing run leaves both flags clear.
- In unequal mode, the redundant decoder sees the vector with its top address bit inverted. The comparator is expected to catch this difference, so a passing run leaves only the compare-logic flag set.

In both modes the start bit drops by itself when the run ends, and software polls for that.

Top module: `ram_dec_selftest`

## Requirements
- R1: After reset, the control and status registers read 0, `bank_sel` is 0 and `acc_block` is 0.
- R2: Outside a test, `bank_sel` is one-hot at the index given by `acc_addr[ADDR_W-1 -: BANK_W]` while `acc_valid` is 1, and is all zero while `acc_valid` is 0.
- R3: A control write (`reg_addr`=0) with bit 8 clear stores the key in bits [3:0] and the mode in bits [7:4]. A control write with bit 8 set leaves the stored key and mode unchanged and requests a test start. Both fields read back in the same positions.
- R4: A start request is accepted only when the stored key is 0xA, the stored mode is 8 (equal) or 4 (unequal), and no test is running. Any other start request is ignored, and control bit 8 stays 0.
- R5: After an accepted start, control bit 8 and `acc_block` read 1 for exactly TEST_CYCLES cycles and then clear by themselves. Throughout that window `bank_sel` is 0, whatever the access inputs are.
- R6: In equal mode, both decoders are fed the test vector's low ADDR_W bits. A passing run sets neither status bit 2 (decode fail) nor status bit 4 (compare-logic fail). A mismatch seen during the run would set both.
- R7: In unequal mode, the redundant decoder gets the vector with bit ADDR_W-1 inverted. A detected mismatch sets status bit 4 only. A run without a mismatch sets status bit 2 only.
- R8: Status bits 2 and 4 (`reg_addr`=2) clear when 1 is written to them. Writing 0 leaves them as they are, and all other status bits read 0. A set from a run that ends in the same cycle as a clear wins over the clear.
- R9: A valid access outside a test whose two decodes differ sets status bit 2 at the next clock edge. Accesses with matching decodes leave the status unchanged.
- R10: The test-vector register (`reg_addr`=1) stores and reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 test vector, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the register chosen by `reg_addr` (combinational) |
| acc_valid | input | 1 | RAM access request |
| acc_addr | input | ADDR_W | RAM access address |
| bank_sel | output | 2**BANK_W | One-hot bank select from the primary decoder |
| acc_block | output | 1 | High while a self-test holds off RAM accesses |

## Verification
The following rules are checked by assertions on every cycle:
- `bank_sel` is never more than one-hot.
- `bank_sel` is blank whenever accesses are held off.
- A hold-off lasts exactly TEST_CYCLES cycles.
- A start request with a wrong key never opens a test.
- The compare-logic flag only rises in the cycle a test ends.
- A one-written to that flag outside a test clears it.

The following can only be shown by the bench scenarios:
- The flag pattern each mode leaves behind, for test vectors with the inverted bit both set and clear.
- That fields are retained across a start-only write.
- That a restart during a run does not stretch the run.
- That a set from a finishing run beats a clear in the same cycle.

// File: rtl/rds_pkg.sv
package rds_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_VEC  = 2'd1;
    localparam logic [1:0] REG_STAT = 2'd2;

    localparam logic [3:0] KEY_RUN   = 4'hA;
    localparam logic [3:0] MODE_SAME = 4'h8;
    localparam logic [3:0] MODE_DIFF = 4'h4;

    localparam int START_BIT    = 8;
    localparam int DEC_FAIL_BIT = 2;
    localparam int CMP_FAIL_BIT = 4;
endpackage

// File: rtl/rds_decoder.sv
module rds_decoder #(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 2,
    localparam int NB = 1 << BANK_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NB-1:0]     sel
);
    logic [BANK_W-1:0] field;
    assign field = addr[ADDR_W-1 -: BANK_W];

    for (genvar i = 0; i < NB; i++) begin : g_line
        assign sel[i] = (field == BANK_W'(i));
    end
endmodule

// File: rtl/rds_compare.sv
module rds_compare #(
    parameter int W = 4
) (
    input  logic [W-1:0] sel_a,
    input  logic [W-1:0] sel_b,
    output logic         differ
);
    logic [W-1:0] bit_diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_diff[i] = sel_a[i] ^ sel_b[i];
    end

    assign differ = |bit_diff;
endmodule

// File: rtl/ram_dec_selftest.sv
module ram_dec_selftest
    import rds_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 2,
    parameter int TEST_CYCLES = 4,
    localparam int NB    = 1 << BANK_W,
    localparam int CNT_W = (TEST_CYCLES > 1) ? $clog2(TEST_CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [NB-1:0]     bank_sel,
    output logic              acc_block
);
    localparam logic [ADDR_W-1:0] FLIP_MASK = {1'b1, {(ADDR_W-1){1'b0}}};

    typedef struct packed {
        logic [3:0]       key;
        logic [3:0]       mode;
        logic [31:0]      vec;
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             f_dec;
        logic             f_cmp;
    } state_t;

    state_t r_q, r_d;

    logic [ADDR_W-1:0] prim_addr, red_addr;
    logic [NB-1:0]     prim_sel, red_sel;
    logic              sel_differ;
    logic              mode_diff_q;
    logic              ctrl_key_ok;
    logic              wr_ctrl, wr_vec, wr_stat;
    logic              ctrl_key_is_run;
    logic              flag_cmp;

    assign mode_diff_q = (r_q.mode == MODE_DIFF);

    // Decoder inputs: the test vector during a run, with the top bit
    // inverted on the redundant side in unequal mode
    assign prim_addr = r_q.busy ? r_q.vec[ADDR_W-1:0] : acc_addr;
    assign red_addr  = (r_q.busy && mode_diff_q) ? (prim_addr ^ FLIP_MASK) : prim_addr;

    rds_decoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec_prim (
        .addr (prim_addr),
        .sel  (prim_sel)
    );

    rds_decoder #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dec_red (
        .addr (red_addr),
        .sel  (red_sel)
    );

    rds_compare #(.W(NB)) u_cmp (
        .sel_a  (prim_sel),
        .sel_b  (red_sel),
        .differ (sel_differ)
    );

    assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
    assign wr_vec  = reg_wr && (reg_addr == REG_VEC);
    assign wr_stat = reg_wr && (reg_addr == REG_STAT);

    assign ctrl_key_ok = (r_q.key == KEY_RUN) &&
                         ((r_q.mode == MODE_SAME) || (r_q.mode == MODE_DIFF));

    always_comb begin
        logic mism_any;
        r_d      = r_q;
        mism_any = r_q.seen | sel_differ;

        // write-one-to-clear on the two diagnostic flags
        if (wr_stat) begin
            if (reg_wdata[DEC_FAIL_BIT]) r_d.f_dec = 1'b0;
            if (reg_wdata[CMP_FAIL_BIT]) r_d.f_cmp = 1'b0;
        end

        if (wr_vec && !r_q.busy) begin
            r_d.vec = reg_wdata;
        end

        if (r_q.busy) begin
            r_d.seen = mism_any;
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
                if (mode_diff_q) begin
                    if (mism_any) r_d.f_cmp = 1'b1;
                    else          r_d.f_dec = 1'b1;
                end else if (mism_any) begin
                    r_d.f_dec = 1'b1;
                    r_d.f_cmp = 1'b1;
                end
            end else begin
                r_d.cnt = r_q.cnt - CNT_W'(1);
            end
        end else begin
            if (acc_valid && sel_differ) begin
                r_d.f_dec = 1'b1;
            end
            if (wr_ctrl) begin
                if (reg_wdata[START_BIT]) begin
                    if (ctrl_key_ok) begin
                        r_d.busy = 1'b1;
                        r_d.cnt  = CNT_W'(TEST_CYCLES - 1);
                        r_d.seen = 1'b0;
                    end
                end else begin
                    r_d.key  = reg_wdata[3:0];
                    r_d.mode = reg_wdata[7:4];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: reg_rdata = {23'd0, r_q.busy, r_q.mode, r_q.key};
            REG_VEC:  reg_rdata = r_q.vec;
            REG_STAT: begin
                reg_rdata[DEC_FAIL_BIT] = r_q.f_dec;
                reg_rdata[CMP_FAIL_BIT] = r_q.f_cmp;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign bank_sel  = (acc_valid && !r_q.busy) ? prim_sel : '0;
    assign acc_block = r_q.busy;

    // taps for the bound checker
    assign ctrl_key_is_run = (r_q.key == KEY_RUN);
    assign flag_cmp        = r_q.f_cmp;
endmodule

// File: rtl/ram_dec_selftest_chk.sv
module ram_dec_selftest_chk #(
    parameter int NB          = 4,
    parameter int TEST_CYCLES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [NB-1:0] bank_sel,
    input logic          acc_block,
    input logic          key_is_run,
    input logic          flag_cmp
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_len <= '0;
        else if (acc_block) run_len <= run_len + 16'd1;
        else                run_len <= '0;
    end

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    assert_block_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_block |-> (bank_sel == '0));

    assert_run_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_block |-> (32'(run_len) < TEST_CYCLES));

    assert_run_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(acc_block) |-> (32'(run_len) == TEST_CYCLES));

    assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_block && reg_wr && reg_addr == 2'd0 && reg_wdata[8] && !key_is_run)
        |=> !acc_block);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_block && reg_wr && reg_addr == 2'd2 && reg_wdata[4]) |=> !flag_cmp);

    assert_cmp_at_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_cmp) |-> $fell(acc_block));
endmodule

bind ram_dec_selftest ram_dec_selftest_chk #(.NB(NB), .TEST_CYCLES(TEST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .bank_sel   (bank_sel),
    .acc_block  (acc_block),
    .key_is_run (ctrl_key_is_run),
    .flag_cmp   (flag_cmp)
);

// File: tb/sim_ram_dec_selftest.sv
`timescale 1ns/1ps
module sim_ram_dec_selftest;
    localparam int ADDR_W = 16;
    localparam int BANK_W = 2;
    localparam int NB     = 4;
    localparam int TC     = 4;
    localparam int NV     = 8;

    // entry: {addr, valid, expected bank_sel}
    localparam logic [ADDR_W+NB:0] TBL [NV] = '{
        {16'h0000, 1'b1, 4'b0001},
        {16'h4000, 1'b1, 4'b0010},
        {16'h8abc, 1'b1, 4'b0100},
        {16'hffff, 1'b1, 4'b1000},
        {16'h3fff, 1'b1, 4'b0001},
        {16'hc000, 1'b0, 4'b0000},
        {16'h7001, 1'b1, 4'b0010},
        {16'hbfff, 1'b1, 4'b0100}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              acc_valid = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [NB-1:0]     bank_sel;
    logic              acc_block;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ram_dec_selftest #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .TEST_CYCLES(TC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .bank_sel(bank_sel), .acc_block(acc_block)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got 0x1 expected 0x0");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd(2'd0, v); check("R1 ctrl", v, 32'h0);
        rd(2'd2, v); check("R1 status", v, 32'h0);
        check("R1 bank_sel", 32'(bank_sel), 32'h0);
        check("R1 acc_block", 32'(acc_block), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: normal decode table
        for (int i = 0; i < NV; i++) begin
            acc_addr  = TBL[i][ADDR_W+NB:NB+1];
            acc_valid = TBL[i][NB];
            #1;
            check("R2 decode", 32'(bank_sel), 32'(TBL[i][NB-1:0]));
            @(negedge clk);
        end
        acc_valid = 1'b0;
        // R9: matching decodes leave status clear
        rd(2'd2, v); check("R9 no flag", v, 32'h0);

        // R10: vector register
        wr(2'd1, 32'h0400ffff);
        rd(2'd1, v); check("R10 vector", v, 32'h0400ffff);

        // R3 / R6: equal mode, vector bank 3
        wr(2'd0, 32'h8a);
        rd(2'd0, v); check("R3 fields", v, 32'h8a);
        wr(2'd2, 32'h781c14);
        acc_valid = 1'b1; acc_addr = 16'h0000;
        wr(2'd0, 32'h100);
        rd(2'd0, v); check("R3 fields kept, start set", v, 32'h18a);
        for (int i = 0; i < TC; i++) begin
            check("R5 block", 32'(acc_block), 32'h1);
            check("R5 sel blank", 32'(bank_sel), 32'h0);
            if (i == 0) begin
                wr(2'd0, 32'h100);   // restart while running: ignored (R4)
                i++;
                check("R5 block", 32'(acc_block), 32'h1);
            end
            if (i < TC - 1) @(negedge clk);
        end
        @(negedge clk);
        check("R5 self clear", 32'(acc_block), 32'h0);
        rd(2'd0, v); check("R5 start bit clear", v, 32'h8a);
        rd(2'd2, v); check("R6 equal pass", v, 32'h0);
        check("R2 sel after run", 32'(bank_sel), 32'h1);
        acc_valid = 1'b0;

        // R7: unequal mode, top bit set in vector
        wr(2'd0, 32'h4a);
        wr(2'd0, 32'h100);
        repeat (TC) @(negedge clk);
        rd(2'd2, v); check("R7 unequal flags", v, 32'h10);
        // R8: write-one-to-clear
        wr(2'd2, 32'h4);
        rd(2'd2, v); check("R8 zero write keeps", v, 32'h10);
        wr(2'd2, 32'hffffffef);
        rd(2'd2, v); check("R8 other ones keep", v, 32'h10);
        wr(2'd2, 32'h10);
        rd(2'd2, v); check("R8 clear", v, 32'h0);

        // R7: top bit clear in vector, plus set beats clear (R8)
        wr(2'd1, 32'h00001234);
        wr(2'd0, 32'h100);
        repeat (TC - 1) @(negedge clk);
        wr(2'd2, 32'h14);
        rd(2'd2, v); check("R8 set wins", v, 32'h10);
        wr(2'd2, 32'h14);

        // R6: equal mode with the same vector
        wr(2'd0, 32'h8a);
        wr(2'd0, 32'h100);
        repeat (TC) @(negedge clk);
        rd(2'd2, v); check("R6 equal pass 2", v, 32'h0);

        // R4: wrong key ignored
        wr(2'd0, 32'h85);
        wr(2'd0, 32'h100);
        check("R4 bad key", 32'(acc_block), 32'h0);
        rd(2'd0, v); check("R4 bad key ctrl", v, 32'h85);
        // R4: bad mode ignored
        wr(2'd0, 32'h2a);
        wr(2'd0, 32'h100);
        check("R4 bad mode", 32'(acc_block), 32'h0);
        rd(2'd0, v); check("R4 bad mode ctrl", v, 32'h2a);

        // R9: accesses after runs do not set flags
        acc_valid = 1'b1; acc_addr = 16'hc123;
        @(negedge clk);
        check("R9 sel", 32'(bank_sel), 32'h8);
        rd(2'd2, v); check("R9 status", v, 32'h0);
        acc_valid = 1'b0;

        finish_run();
    end
endmodule